// File: doc/BRIEF.md
# Serial ADC Scan Host Controller

This block runs one scan on a 16-bit serial analog-to-digital converter that takes a command byte and then converts on its own internal clock. A start request in idle lowers chip select and sends the command byte on the data-in line, most significant bit first. It then gives eight more SCLK pulses with data-in held low, so the frame has sixteen pulses in all. After the sixteenth pulse SCLK is held low while the converter samples and converts. The host waits for the end-of-conversion line to fall. It then clocks in one or more 16-bit result words, most significant bit first, releases chip select, and presents the packed words with a one-cycle valid strobe.

SCLK follows SPI mode 0. It idles low, the converter captures data-in on rising edges, and the host changes data-in only at falling edges. SCLK is derived from the system clock by an even divide ratio. The end-of-conversion input is asynchronous to the system clock, so it passes through a synchronizer before its falling edge is detected. A wait counter bounds the conversion phase. If no falling edge comes in time, the scan is abandoned and an error flag is raised.

Top module: `adc_scan_host`

## Requirements
- R1: While reset is high, and in idle, adc_cs_n is 1 and adc_sclk, adc_din and busy are 0. Reset is synchronous. A reset asserted in the middle of a scan gives these values from the first clock after reset is sampled.
- R2: When start is high and the block is idle, adc_cs_n is 0 and busy is 1 from the next clock. A start while busy changes nothing: the lines, the timing and the result of the scan already running are unaffected.
- R3: Each SCLK half period lasts SCLK_DIV/2 system clocks. SCLK is low for one full half period after adc_cs_n falls before its first rise, and SCLK is high only while adc_cs_n is 0.
- R4: The frame has 2*CMD_W SCLK pulses. During pulse k (k = 0 first) adc_din carries cmd[CMD_W-1-k] for k < CMD_W, and 0 after that. adc_din changes only on the clock where SCLK falls.
- R5: After the last frame pulse falls, SCLK and adc_din stay low and adc_cs_n stays low until the read phase or an abort.
- R6: The read phase starts three clocks after adc_eoc is first sampled low while waiting, with the first read half period low. Only a 1-to-0 change of adc_eoc is used, and it must be detected during the wait. A level that is already low when the wait begins does not start a read.
- R7: The read phase gives 16*N SCLK pulses, where N is the words input sampled at start, with 0 read as 1 and values above MAX_CONV read as MAX_CONV. adc_dout is sampled on the clock where SCLK rises, most significant bit first.
- R8: In result_data the most recently read word is in bits [DATA_W-1:0], and each earlier word sits DATA_W bits higher. Bits above the words read are 0.
- R9: On the clock after the last read pulse falls, adc_cs_n is 1, busy is 0 and result_valid is 1 for exactly one cycle.
- R10: If no falling edge is detected within TIMEOUT_CYC clocks of waiting, then on the next clock adc_cs_n is 1, busy is 0 and timeout_err is 1, and result_valid stays 0. A falling edge detected on the last waiting clock still starts the read. timeout_err stays 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Scan request, taken only when idle |
| cmd | input | CMD_W | Command byte sent at the start of the frame |
| words | input | $clog2(MAX_CONV+1) | Number of result words to read (clamped) |
| busy | output | 1 | High from an accepted start until the scan ends |
| result_valid | output | 1 | One-cycle strobe marking result_data as new |
| result_data | output | DATA_W*MAX_CONV | Packed result words, newest in the low bits |
| timeout_err | output | 1 | Set when a scan is aborted for lack of EOC |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_din | output | 1 | Serial data to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| adc_eoc | input | 1 | End-of-conversion line, asynchronous |

## Verification
A wrong phase or pulse count shows at the ports within one SCLK half period. SCLK either keeps toggling after the sixteenth frame pulse or stops early, and adc_cs_n rises one half period too soon or too late. A wrong bit pointer in the command shift shows on adc_din at the falling edge where it occurs, and a wrong read shift shows only at the result_valid strobe, as a mismatched result_data word. A fault in the wait counter or the edge detector moves the read phase or the abort by whole clocks. The bench exercises the exact boundary, where a falling edge is detected on the last waiting clock or one clock later.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_CONVWAIT,
        ST_READ
    } scan_state_e;

endpackage

// File: rtl/adc_scan_divider.sv
// Half-period strobe generator for the serial clock. The counter restarts
// whenever it is disabled, so every burst begins with a full half period.
module adc_scan_divider #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    generate
        if (HALF == 1) begin : g_direct
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick = en;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            localparam logic [CW-1:0] LAST = CW'(HALF - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!en || cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick = en && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/adc_scan_eoc_sync.sv
// Multi-stage synchronizer for the end-of-conversion line with a falling-edge
// detector behind it. All stages reset to the idle-high level.
module adc_scan_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eoc_in,
    output logic fall
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign sync_d[i] = eoc_in;
            end else begin : g_next
                assign sync_d[i] = sync_q[i-1];
            end
        end
    endgenerate

    assign last_d = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host #(
    parameter int SCLK_DIV    = 4,
    parameter int CMD_W       = 8,
    parameter int DATA_W      = 16,
    parameter int MAX_CONV    = 2,
    parameter int TIMEOUT_CYC = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic [CMD_W-1:0]                    cmd,
    input  logic [$clog2(MAX_CONV+1)-1:0]       words,
    output logic                                busy,
    output logic                                result_valid,
    output logic [DATA_W*MAX_CONV-1:0]          result_data,
    output logic                                timeout_err,
    output logic                                adc_cs_n,
    output logic                                adc_sclk,
    output logic                                adc_din,
    input  logic                                adc_dout,
    input  logic                                adc_eoc
);

    import adc_scan_pkg::*;

    localparam int HALF         = SCLK_DIV / 2;
    localparam int FRAME_PULSES = 2 * CMD_W;
    localparam int RES_W        = DATA_W * MAX_CONV;
    localparam int MAX_PULSES   = (FRAME_PULSES > RES_W) ? FRAME_PULSES : RES_W;
    localparam int ECW          = $clog2(MAX_PULSES + 1);
    localparam int WCW          = $clog2(MAX_CONV + 1);
    localparam int TCW          = $clog2(TIMEOUT_CYC + 1);

    localparam logic [ECW-1:0] FRAME_END = ECW'(FRAME_PULSES);
    localparam logic [TCW-1:0] WAIT_LAST = TCW'(TIMEOUT_CYC - 1);
    localparam logic [WCW-1:0] WORDS_MAX = WCW'(MAX_CONV);

    typedef struct packed {
        scan_state_e      state;
        logic             cs_n;
        logic             sclk;
        logic             din;
        logic [CMD_W-1:0] cmd_sh;
        logic [ECW-1:0]   pulses;
        logic [WCW-1:0]   nwords;
        logic [RES_W-1:0] rx_sh;
        logic [TCW-1:0]   timer;
        logic             valid;
        logic [RES_W-1:0] result;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic           half_tick;
    logic           eoc_fall;
    logic           clk_en;
    logic [ECW-1:0] read_pulses;
    logic [WCW-1:0] words_eff;

    assign clk_en = (r_q.state == ST_FRAME) || (r_q.state == ST_READ);

    adc_scan_divider #(
        .HALF (HALF)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .tick (half_tick)
    );

    adc_scan_eoc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_eoc (
        .clk    (clk),
        .rst    (rst),
        .eoc_in (adc_eoc),
        .fall   (eoc_fall)
    );

    // Word count as used for this scan: zero reads one word, excess is capped.
    always_comb begin
        if (words == '0) begin
            words_eff = WCW'(1);
        end else if (words > WORDS_MAX) begin
            words_eff = WORDS_MAX;
        end else begin
            words_eff = words;
        end
    end

    assign read_pulses = ECW'(r_q.nwords) * ECW'(DATA_W);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state  = ST_FRAME;
                    r_d.cs_n   = 1'b0;
                    r_d.sclk   = 1'b0;
                    r_d.din    = cmd[CMD_W-1];
                    r_d.cmd_sh = {cmd[CMD_W-2:0], 1'b0};
                    r_d.pulses = '0;
                    r_d.nwords = words_eff;
                    r_d.rx_sh  = '0;
                    r_d.timer  = '0;
                    r_d.err    = 1'b0;
                end
            end

            ST_FRAME: begin
                if (half_tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk   = 1'b1;
                        r_d.pulses = r_q.pulses + 1'b1;
                    end else begin
                        r_d.sclk   = 1'b0;
                        r_d.din    = r_q.cmd_sh[CMD_W-1];
                        r_d.cmd_sh = {r_q.cmd_sh[CMD_W-2:0], 1'b0};
                        if (r_q.pulses == FRAME_END) begin
                            r_d.state  = ST_CONVWAIT;
                            r_d.din    = 1'b0;
                            r_d.pulses = '0;
                            r_d.timer  = '0;
                        end
                    end
                end
            end

            ST_CONVWAIT: begin
                if (eoc_fall) begin
                    r_d.state  = ST_READ;
                    r_d.pulses = '0;
                end else if (r_q.timer == WAIT_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.cs_n  = 1'b1;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.timer = r_q.timer + 1'b1;
                end
            end

            ST_READ: begin
                if (half_tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk   = 1'b1;
                        r_d.rx_sh  = {r_q.rx_sh[RES_W-2:0], adc_dout};
                        r_d.pulses = r_q.pulses + 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.pulses == read_pulses) begin
                            r_d.state  = ST_IDLE;
                            r_d.cs_n   = 1'b1;
                            r_d.valid  = 1'b1;
                            r_d.result = r_q.rx_sh;
                        end
                    end
                end
            end

            default: begin
                r_d.state = ST_IDLE;
                r_d.cs_n  = 1'b1;
                r_d.sclk  = 1'b0;
                r_d.din   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state  <= ST_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.sclk   <= 1'b0;
            r_q.din    <= 1'b0;
            r_q.cmd_sh <= '0;
            r_q.pulses <= '0;
            r_q.nwords <= '0;
            r_q.rx_sh  <= '0;
            r_q.timer  <= '0;
            r_q.valid  <= 1'b0;
            r_q.result <= '0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign result_valid = r_q.valid;
    assign result_data  = r_q.result;
    assign timeout_err  = r_q.err;
    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign adc_din      = r_q.din;

endmodule

// File: rtl/adc_scan_host_chk.sv
module adc_scan_host_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic result_valid,
    input logic timeout_err,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_din
);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (adc_cs_n && !adc_sclk && !adc_din));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !adc_cs_n));

    assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_cs_n);

    assert_din_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && $past(!adc_cs_n) && !$fell(adc_sclk)) |-> $stable(adc_din));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    assert_valid_closes_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (adc_cs_n && !busy && $rose(adc_cs_n)));

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> (!result_valid && !busy && adc_cs_n));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (timeout_err && !start) |=> timeout_err);

endmodule

bind adc_scan_host adc_scan_host_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .result_valid (result_valid),
    .timeout_err  (timeout_err),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_din      (adc_din)
);

// File: tb/adc_scan_host_test.sv
`timescale 1ns/1ps
module adc_scan_host_test;

    localparam int DIV  = 4;
    localparam int H    = DIV / 2;
    localparam int T    = 40;
    localparam int MAXC = 2;
    localparam int DW   = 16;
    localparam int RW   = DW * MAXC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    cmd = 8'h00;
    logic [1:0]    words = 2'd0;
    logic          busy, result_valid, timeout_err;
    logic [RW-1:0] result_data;
    logic          adc_cs_n, adc_sclk, adc_din;
    logic          adc_dout;
    logic          adc_eoc = 1'b1;

    adc_scan_host #(
        .SCLK_DIV    (DIV),
        .CMD_W       (8),
        .DATA_W      (DW),
        .MAX_CONV    (MAXC),
        .TIMEOUT_CYC (T),
        .SYNC_STAGES (2)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cmd          (cmd),
        .words        (words),
        .busy         (busy),
        .result_valid (result_valid),
        .result_data  (result_data),
        .timeout_err  (timeout_err),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .adc_din      (adc_din),
        .adc_dout     (adc_dout),
        .adc_eoc      (adc_eoc)
    );

    // Converter model: presents the next stream bit after each SCLK fall.
    logic [RW-1:0] dev_bits = '0;
    int            rd_idx = 0;
    logic          rd_on = 1'b0;

    assign adc_dout = (rd_on && rd_idx < RW) ? dev_bits[RW-1-rd_idx] : 1'b0;

    always @(negedge adc_sclk) begin
        if (rd_on) rd_idx = rd_idx + 1;
    end

    typedef struct packed {
        logic          cs_n;
        logic          sclk;
        logic          din;
        logic          busy;
        logic          valid;
        logic          err;
        logic          chk_res;
        logic [RW-1:0] res;
    } exp_t;

    exp_t  q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    chk_off = 1'b1;
    bit    finished = 1'b0;
    logic  idle_err = 1'b0;

    function automatic void push(logic cs, logic sc, logic di, logic bz,
                                 logic v, logic e, logic cr, logic [RW-1:0] r);
        exp_t x;
        x.cs_n = cs; x.sclk = sc; x.din = di; x.busy = bz;
        x.valid = v; x.err = e; x.chk_res = cr; x.res = r;
        q.push_back(x);
    endfunction

    function automatic void chk1(string sig, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, sig, act, exp, $time);
        end
    endfunction

    always @(negedge clk) begin : cmp
        exp_t e;
        if (!chk_off && !finished) begin
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e = '0;
                e.cs_n = 1'b1;
                e.err  = idle_err;
            end
            chk1("adc_cs_n", adc_cs_n, e.cs_n);
            chk1("adc_sclk", adc_sclk, e.sclk);
            chk1("adc_din", adc_din, e.din);
            chk1("busy", busy, e.busy);
            chk1("result_valid", result_valid, e.valid);
            chk1("timeout_err", timeout_err, e.err);
            if (e.chk_res) begin
                n_checks++;
                if (result_data !== e.res) begin
                    n_fail++;
                    $display("FAIL %s result_data actual=%h expected=%h", tag, result_data, e.res);
                end
            end
        end
    end

    // One scan. d: clocks after entering the wait before adc_eoc is driven low.
    task automatic run_scan(input logic [7:0] c, input logic [1:0] nin, input int neff,
                            input logic [15:0] w0, input logic [15:0] w1,
                            input int d, input bit early);
        bit to;
        to = early || (d + 3 > T);
        dev_bits = {w0, w1};
        @(negedge clk);
        cmd = c; words = nin; start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        for (int p = 0; p < 32; p++) begin
            for (int k = 0; k < H; k++) begin
                push(1'b0, (p % 2) == 1, (p / 2 < 8) ? c[7 - p / 2] : 1'b0,
                     1'b1, 1'b0, 1'b0, 1'b0, '0);
            end
        end
        if (to) begin
            for (int k = 0; k < T; k++) push(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            push(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        end else begin
            for (int k = 0; k < d + 3; k++) push(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            for (int p = 0; p < 32 * neff; p++) begin
                for (int k = 0; k < H; k++) begin
                    push(1'b0, (p % 2) == 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
                end
            end
            push(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                 (neff == 1) ? {16'h0000, w0} : {w0, w1});
        end
        if (early) begin
            repeat (10) @(posedge clk);
            @(negedge clk);
            adc_eoc = 1'b0;
        end else begin
            repeat (32 * H + d) @(posedge clk);
            @(negedge clk);
            adc_eoc = 1'b0;
            rd_idx = 0;
            rd_on = 1'b1;
        end
        wait (q.size() == 0);
        idle_err = to;
        @(negedge clk);
        adc_eoc = 1'b1;
        rd_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state while held and just after release
        tag = "R1";
        repeat (3) @(negedge clk);
        chk1("adc_cs_n", adc_cs_n, 1'b1);
        chk1("adc_sclk", adc_sclk, 1'b0);
        chk1("adc_din", adc_din, 1'b0);
        chk1("busy", busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk1("busy", busy, 1'b0);
        chk1("result_valid", result_valid, 1'b0);
        chk_off = 1'b0;

        tag = "R3 R4";
        run_scan(8'hA5, 2'd1, 1, 16'hC3A5, 16'h0000, 5, 1'b0);

        tag = "R7 R8";
        run_scan(8'h3C, 2'd2, 2, 16'h1234, 16'hABCD, 0, 1'b0);

        tag = "R7";
        run_scan(8'h81, 2'd0, 1, 16'h8001, 16'h0000, 2, 1'b0);
        run_scan(8'h7E, 2'd3, 2, 16'hFFFF, 16'h0001, 1, 1'b0);

        // R5 R6: fall detected on the last waiting clock still reads
        tag = "R5 R6";
        run_scan(8'h55, 2'd1, 1, 16'h5AA5, 16'h0000, T - 3, 1'b0);

        // R10: one clock later aborts; then the next start clears the flag
        tag = "R10";
        run_scan(8'hAA, 2'd1, 1, 16'h1111, 16'h0000, T - 2, 1'b0);
        run_scan(8'h0F, 2'd1, 1, 16'h0F0F, 16'h0000, 4, 1'b0);

        // R6: adc_eoc already low when the wait begins gives no read
        tag = "R6";
        run_scan(8'h33, 2'd1, 1, 16'h0000, 16'h0000, 0, 1'b1);

        // R2: start while busy is ignored
        tag = "R2";
        fork
            run_scan(8'h96, 2'd1, 1, 16'hBEEF, 16'h0000, 3, 1'b0);
            begin
                repeat (20) @(negedge clk);
                start = 1'b1; cmd = 8'hFF; words = 2'd2;
                @(negedge clk);
                start = 1'b0;
            end
        join

        // R1: reset in the middle of a frame
        tag = "R1";
        chk_off = 1'b1;
        @(negedge clk);
        cmd = 8'hF0; words = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk1("busy", busy, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk1("adc_cs_n", adc_cs_n, 1'b1);
        chk1("adc_sclk", adc_sclk, 1'b0);
        chk1("adc_din", adc_din, 1'b0);
        chk1("busy", busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk1("busy", busy, 1'b0);
        q.delete();
        idle_err = 1'b0;
        chk_off = 1'b0;

        tag = "R9";
        run_scan(8'hC0, 2'd2, 2, 16'h8000, 16'h7FFF, 7, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule